// File: doc/BRIEF.md
# Soft-Start PWM Output Sequencer

This block drives one differential pulse-width-modulated output pair for an audio power stage. A free-running carrier counter sets the switching period. Every period, a signed audio command is scaled by an internal gain value and becomes a pair of mirrored duty cycles around 50 %. Gain is never applied abruptly, which avoids audible clicks.

When the enable input rises, the outputs first switch at a flat 50 % for a bias interval so the common mode settles. The gain then climbs linearly to full scale. When enable falls, the gain falls linearly to zero, and only then are the outputs parked low. The mute input keeps the stage running. It ramps the gain down to zero so that both outputs carry an unmodulated 50 % square wave. Releasing mute ramps the gain back up.

Ramp speeds are set by three prescale parameters, in carrier periods per gain step: one for rising, one for falling on mute, and one for falling on disable. A 315 kHz carrier with a 12-bit gain gives about 450 ms up, about 120 ms mute-out and under 150 ms shutdown.

Top module: `softstart_pwm`

## Requirements
- R1: While the stage is inactive (`active` low), both PWM outputs are low. After reset the block is inactive and `busy` is low.
- R2: On a rising `en`, `active` and `busy` go high. For BIAS_PER carrier periods both outputs run at exactly CAR_DIV/2 high cycles per period, whatever the command. The gain then rises by one step every UP_DIV periods and never falls while `en` is high and `mute` is low.
- R3: In steady unmuted operation with gain G=2^GAIN_W-1, the offset is off = floor(cmd*G / 2^GAIN_W). Within each period, `pwm_p` is high for CAR_DIV/2+off cycles and `pwm_n` for CAR_DIV/2-off cycles.
- R4: The offset is clamped to ±CAR_DIV/2, so an oversized command gives a fully high `pwm_p` and a fully low `pwm_n` (or the reverse for a negative command).
- R5: With `mute` high and `busy` low, both outputs switch identically at CAR_DIV/2 high cycles per period, with no dependence on `cmd`, and `active` stays high.
- R6: After `en` falls, the gain never increases and changes by at most one step per cycle. A fall during a ramp-up continues downward from the current gain, so modulation persists at first.
- R7: After `en` falls, `active` drops only once the gain has reached zero. This takes (2^GAIN_W-1)·DN_DIV carrier periods from full gain.
- R8: A full unmute ramp takes (2^GAIN_W-1)·UP_DIV periods. A full mute-out ramp takes (2^GAIN_W-1)·MUTE_DIV periods. `busy` is high exactly while the gain differs from its target or the bias interval runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Stage enable; low ramps down and shuts the outputs off |
| mute | input | 1 | High ramps audio out and leaves a 50 % carrier |
| cmd | input | AUD_W | Signed audio command, in carrier ticks of offset at full gain |
| pwm_p | output | 1 | Positive PWM output |
| pwm_n | output | 1 | Negative PWM output |
| active | output | 1 | Output stage switching |
| busy | output | 1 | Bias interval or gain ramp in progress |

## Verification
The bench measures high-cycle counts over whole carrier periods, so it checks duty without depending on the carrier phase. Negative commands catch a design that rounds toward zero instead of flooring, and oversized commands catch a missing clamp, which would wrap the duty. A disable issued partway through a ramp-up catches a design that jumps the gain to zero, since the next period would already sit at 50 %. Timed ramps catch swapped or shared prescalers: a mute-out running at the shutdown rate, or a missing bias interval, falls outside the accepted window.

// File: rtl/softstart_pwm.sv
module softstart_pwm #(
  parameter int CAR_DIV  = 397,
  parameter int GAIN_W   = 12,
  parameter int AUD_W    = 16,
  parameter int BIAS_PER = 64,
  parameter int UP_DIV   = 35,
  parameter int MUTE_DIV = 9,
  parameter int DN_DIV   = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             mute,
  input  logic [AUD_W-1:0] cmd,
  output logic             pwm_p,
  output logic             pwm_n,
  output logic             active,
  output logic             busy
);
  localparam int CW = $clog2(CAR_DIV);
  localparam int PW = AUD_W + GAIN_W + 1;
  localparam int BW = $clog2(BIAS_PER + 1);
  localparam logic [GAIN_W-1:0] GMAX = {GAIN_W{1'b1}};
  localparam logic signed [PW-1:0] HALF = PW'(CAR_DIV / 2);

  typedef enum logic [1:0] {S_OFF, S_BIAS, S_RUN} st_t;
  st_t st;

  logic [CW-1:0] cnt;
  logic [15:0] pre, pre_nxt;
  logic [BW-1:0] bcnt;
  logic [GAIN_W-1:0] gain, gain_nxt, tgt;
  logic [CW:0] duty_p, duty_n;
  logic tick;

  assign tick = (cnt == CW'(CAR_DIV - 1));
  assign tgt = (en && !mute) ? GMAX : '0;
  assign active = (st != S_OFF);
  assign busy = (st == S_BIAS) || (st == S_RUN && gain != tgt);

  always_comb begin
    logic [15:0] div;
    div = (gain < tgt) ? 16'(UP_DIV) : (en ? 16'(MUTE_DIV) : 16'(DN_DIV));
    gain_nxt = gain;
    pre_nxt = pre;
    if (tick && st == S_RUN) begin
      if (gain == tgt) pre_nxt = '0;
      else if (pre >= div - 16'd1) begin
        pre_nxt = '0;
        gain_nxt = (gain < tgt) ? gain + 1'b1 : gain - 1'b1;
      end else pre_nxt = pre + 16'd1;
    end
  end

  logic signed [PW-1:0] prod, off, offc, dp, dn;
  always_comb begin
    prod = $signed({{(PW-AUD_W){cmd[AUD_W-1]}}, cmd}) * $signed(PW'({1'b0, gain_nxt}));
    off = prod >>> GAIN_W;
    offc = (off > HALF) ? HALF : ((off < -HALF) ? -HALF : off);
    dp = HALF + offc;
    dn = HALF - offc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_OFF;
      cnt <= '0;
      pre <= '0;
      bcnt <= '0;
      gain <= '0;
      duty_p <= '0;
      duty_n <= '0;
      pwm_p <= 1'b0;
      pwm_n <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + 1'b1;
      gain <= gain_nxt;
      pre <= pre_nxt;
      if (tick) begin
        duty_p <= dp[CW:0];
        duty_n <= dn[CW:0];
      end
      pwm_p <= active && ({1'b0, cnt} < duty_p);
      pwm_n <= active && ({1'b0, cnt} < duty_n);
      case (st)
        S_OFF: if (en) begin
          st <= S_BIAS;
          bcnt <= '0;
        end
        S_BIAS: begin
          if (!en) st <= S_OFF;
          else if (tick) begin
            if (bcnt == BW'(BIAS_PER - 1)) begin
              st <= S_RUN;
              pre <= '0;
            end
            bcnt <= bcnt + 1'b1;
          end
        end
        default: if (!en && gain == '0) st <= S_OFF;
      endcase
    end
  end
endmodule

module softstart_pwm_chk #(
  parameter int GAIN_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              mute,
  input logic              pwm_p,
  input logic              pwm_n,
  input logic              active,
  input logic              busy,
  input logic [GAIN_W-1:0] gain
);
  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !active |=> (!pwm_p && !pwm_n));
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(active) |-> busy);
  // R2
  ramp_up_mono_chk: assert property (@(posedge clk) disable iff (rst)
    (active && en && !mute) |=> (gain >= $past(gain)));
  // R5
  mute_flat_chk: assert property (@(posedge clk) disable iff (rst)
    (active && en && mute && !busy) |=> (pwm_p == pwm_n));
  // R6
  no_rise_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (gain <= $past(gain)));
  // R6
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (gain == $past(gain) || gain == $past(gain) + 1'b1 || gain == $past(gain) - 1'b1));
  // R7
  off_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(active) |-> (gain == '0));
endmodule

bind softstart_pwm softstart_pwm_chk #(.GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst(rst), .en(en), .mute(mute), .pwm_p(pwm_p), .pwm_n(pwm_n),
  .active(active), .busy(busy), .gain(gain));

// File: tb/sim_softstart_pwm.sv
module sim_softstart_pwm;
  localparam int CAR = 16, GW = 4, AW = 8, BIAS = 4, UPD = 3, MD = 2, DND = 1;
  localparam int STEPS = (1 << GW) - 1;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0, mute = 1'b0;
  logic [AW-1:0] cmd = '0;
  logic pwm_p, pwm_n, active, busy;
  int tests = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  softstart_pwm #(.CAR_DIV(CAR), .GAIN_W(GW), .AUD_W(AW), .BIAS_PER(BIAS),
    .UP_DIV(UPD), .MUTE_DIV(MD), .DN_DIV(DND)) u0 (
    .clk(clk), .rst(rst), .en(en), .mute(mute), .cmd(cmd),
    .pwm_p(pwm_p), .pwm_n(pwm_n), .active(active), .busy(busy));

  typedef struct packed { logic [7:0] c; logic m; logic [7:0] ep; logic [7:0] en_; } vec_t;
  localparam vec_t VEC [8] = '{
    '{8'sd4,   1'b0, 8'd11, 8'd5},
    '{-8'sd4,  1'b0, 8'd4,  8'd12},
    '{8'sd8,   1'b0, 8'd15, 8'd1},
    '{8'sd20,  1'b0, 8'd16, 8'd0},
    '{-8'sd20, 1'b0, 8'd0,  8'd16},
    '{8'sd0,   1'b0, 8'd8,  8'd8},
    '{8'sd8,   1'b1, 8'd8,  8'd8},
    '{-8'sd20, 1'b1, 8'd8,  8'd8}};

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    tests++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic measure(output int hp, output int hn);
    hp = 0; hn = 0;
    for (int i = 0; i < CAR; i++) begin
      @(negedge clk);
      hp += int'(pwm_p);
      hn += int'(pwm_n);
    end
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    @(negedge clk); n++;
    while (busy && n < 5000) begin @(negedge clk); n++; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: got %0d expected 0", cyc);
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
      $finish;
    end
  end

  initial begin
    int hp, hn, n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 active", int'(active), 0);
    check("R1 busy", int'(busy), 0);
    measure(hp, hn);
    check("R1 p low", hp + hn, 0);

    // R2 bias interval at 50 % with a nonzero command
    cmd = 8'sd8;
    en = 1'b1;
    @(negedge clk);
    check("R2 active", int'(active), 1);
    check("R2 busy", int'(busy), 1);
    @(negedge clk);
    measure(hp, hn);
    check("R2 bias p", hp, CAR / 2);
    check("R2 bias n", hn, CAR / 2);
    en = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 off from bias", int'(active), 0);

    // R8 full turn-on time: bias plus ramp
    @(negedge clk);
    en = 1'b1;
    wait_idle(n);
    check_rng("R8 turn-on", n, (BIAS + STEPS * UPD - 1) * CAR, (BIAS + STEPS * UPD) * CAR + 3);

    // R3 R4 R5 vector table
    foreach (VEC[i]) begin
      cmd = VEC[i].c;
      mute = VEC[i].m;
      wait_idle(n);
      repeat (2 * CAR) @(negedge clk);
      measure(hp, hn);
      check(VEC[i].m ? "R5 p" : "R3/R4 p", hp, int'(VEC[i].ep));
      check(VEC[i].m ? "R5 n" : "R3/R4 n", hn, int'(VEC[i].en_));
      if (VEC[i].m) check("R5 active", int'(active), 1);
    end

    // R8 unmute and mute-out durations
    mute = 1'b0;
    wait_idle(n);
    check_rng("R8 unmute", n, (STEPS * UPD - 1) * CAR, STEPS * UPD * CAR + 3);
    mute = 1'b1;
    wait_idle(n);
    check_rng("R8 mute-out", n, (STEPS * MD - 1) * CAR, STEPS * MD * CAR + 3);
    mute = 1'b0;
    wait_idle(n);

    // R7 shutdown duration from full gain
    en = 1'b0;
    n = 0;
    while (active && n < 5000) begin @(negedge clk); n++; end
    check_rng("R7 shutdown", n, (STEPS * DND - 1) * CAR, STEPS * DND * CAR + 3);
    measure(hp, hn);
    check("R1 low after off", hp + hn, 0);

    // R6 disable during ramp-up reverses from current gain
    cmd = 8'sd8;
    en = 1'b1;
    repeat ((BIAS + 20) * CAR) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    measure(hp, hn);
    check("R6 still active", int'(active), 1);
    check_rng("R6 modulation kept", hp, CAR / 2 + 1, CAR);
    n = 0;
    while (active && n < 5000) begin @(negedge clk); n++; end
    check("R7 reached off", int'(active), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule